// File: doc/BRIEF.md
# Masked Address Decoder with Translation

This block decides whether a 32-bit bus address falls inside one programmable address window and produces the address to forward downstream. Four registers define the window. Software writes them through a small write port:

- a base address,
- a size mask,
- a replacement (translation) address,
- a control word.

The mask may be written with any pattern. Before the mask reaches the comparator, it is repaired into a run of ones that starts at bit 31. A single base register therefore always describes exactly one window. The window is aligned to 4 KB and is at most 2 GB in size.

The decode path is purely combinational from `in_addr` to `hit` and `out_addr`. Register contents change only on a clock edge. When translation is on, the upper address bits covered by the repaired mask are replaced with the matching bits of the translation register. The lower bits always pass through unchanged. When translation is off, the address passes through untouched.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset all four registers read zero, `hit` is 0 and `out_addr` equals `in_addr`.
- R2: When `cfg_we` is 1, the register chosen by `cfg_sel` takes `cfg_wdata` at the rising clock edge. The select codes are 0 = base, 1 = mask, 2 = translation, 3 = control. `cfg_rdata` shows the selected register combinationally. Decoding uses the new value from the cycle after the edge, and uses the old value before it.
- R3: While mask bit 31 is 0, `hit` stays 0 for every input address.
- R4: The effective mask keeps bit 31 as written. Each bit from 30 down to 12 is one only if it was written one and every effective bit above it is one. So all bits below the highest written zero are cleared.
- R5: `hit` is 1 exactly when (`in_addr` AND effective mask) equals (base AND effective mask), with mask bit 31 set.
- R6: When control bit 2 is 1, `out_addr` = (`in_addr` AND NOT effective mask) OR (translation AND effective mask).
- R7: When control bit 2 is 0, `out_addr` equals `in_addr`.
- R8: Mask bits 11..0 are stored as zero and read back as zero. The control register keeps only bit 2, and its other bits read zero. The mask reads back as written above bit 11, before repair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 mask, 2 translation, 3 control |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| in_addr | input | 32 | Address to decode |
| hit | output | 1 | Address lies inside the enabled window |
| out_addr | output | 32 | Translated or passed-through address |

## Verification
A register write and a decode can land in the same cycle. The decode is combinational, so an address held steady across a write edge must be judged against the old settings just before the edge and against the new ones just after it. The bench holds one address fixed and raises a base or control write in the same cycle. It samples `hit` and `out_addr` a nanosecond before the rising edge and again a nanosecond after it. It expects the old decision first and the new decision second.

// File: rtl/addr_window_xlat.sv
module addr_window_xlat #(
  parameter int AW     = 32,
  parameter int PAGE_B = 12,
  parameter int XBIT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic [AW-1:0] in_addr,
  output logic          hit,
  output logic [AW-1:0] out_addr
);
  localparam int TOP = AW - 1;
  localparam logic [AW-1:0] PAGE_KEEP = {{(AW-PAGE_B){1'b1}}, {PAGE_B{1'b0}}};

  logic [AW-1:0] base_q, mask_q, xlat_q;
  logic          xen_q;
  logic [AW-1:0] emask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      xlat_q <= '0;
      xen_q  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: base_q <= cfg_wdata;
        2'd1: mask_q <= cfg_wdata & PAGE_KEEP;
        2'd2: xlat_q <= cfg_wdata;
        default: xen_q <= cfg_wdata[XBIT];
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0: cfg_rdata = base_q;
      2'd1: cfg_rdata = mask_q;
      2'd2: cfg_rdata = xlat_q;
      default: begin
        cfg_rdata = '0;
        cfg_rdata[XBIT] = xen_q;
      end
    endcase
  end

  assign emask[TOP] = mask_q[TOP];
  genvar i;
  generate
    for (i = TOP - 1; i >= PAGE_B; i--) begin : g_fix
      assign emask[i] = mask_q[i] & emask[i+1];
    end
  endgenerate
  assign emask[PAGE_B-1:0] = '0;

  assign hit      = emask[TOP] && ((in_addr & emask) == (base_q & emask));
  assign out_addr = xen_q ? ((in_addr & ~emask) | (xlat_q & emask)) : in_addr;

  p_no_hit_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1 && !cfg_wdata[TOP]) |=> (!(cfg_we && cfg_sel == 2'd1) -> !hit));

  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3 && !cfg_wdata[XBIT]) |=> (out_addr == in_addr));

  p_page_bits_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_addr[PAGE_B-1:0] == in_addr[PAGE_B-1:0]);

  p_mask_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd1) |-> (cfg_rdata[PAGE_B-1:0] == '0));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2) |=> (cfg_sel == 2'd2 -> cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/sim_addr_window_xlat.sv
module sim_addr_window_xlat;
  logic clk = 0, rst_n = 0, cfg_we = 0, hit;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, in_addr = 0, out_addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  addr_window_xlat u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_addr(in_addr), .hit(hit), .out_addr(out_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    in_addr = a;
    #1;
  endtask

  task automatic rd(input logic [1:0] s, input string req, input logic [31:0] exp);
    @(negedge clk);
    cfg_sel = s;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic t_reset;
    look(32'h8765_4321);
    chk("R1 hit", {31'b0, hit}, 0);
    chk("R1 out", out_addr, 32'h8765_4321);
    for (int k = 0; k < 4; k++) rd(k[1:0], "R1 regs", 0);
  endtask

  task automatic t_readback;
    wr(1, 32'hFFFF_FFFF); rd(1, "R8 mask low", 32'hFFFF_F000);
    wr(3, 32'hFFFF_FFFF); rd(3, "R8 ctrl", 32'h0000_0004);
    wr(2, 32'hDEAD_BEEF); rd(2, "R2 xlat", 32'hDEAD_BEEF);
    wr(0, 32'h1357_9BDF); rd(0, "R2 base", 32'h1357_9BDF);
    wr(3, 0); wr(2, 0);
  endtask

  task automatic t_disabled;
    wr(0, 0); wr(1, 32'h7FFF_F000);
    look(32'h0000_0000); chk("R3 zero addr", {31'b0, hit}, 0);
    look(32'h0000_0ABC); chk("R3 inside", {31'b0, hit}, 0);
  endtask

  task automatic t_hit;
    wr(1, 32'hFFFF_0000); wr(0, 32'h1234_0000);
    look(32'h1234_5678); chk("R5 match", {31'b0, hit}, 1);
    look(32'h1235_0000); chk("R5 miss", {31'b0, hit}, 0);
    look(32'h9234_0000); chk("R5 top miss", {31'b0, hit}, 0);
    wr(1, 32'hFFFF_FFFF); wr(0, 32'h0000_5000);
    look(32'h0000_5FFF); chk("R5 4KB hit", {31'b0, hit}, 1);
    look(32'h0000_6000); chk("R5 4KB miss", {31'b0, hit}, 0);
  endtask

  task automatic t_fix;
    wr(1, 32'hF0F0_0000); wr(0, 32'h1000_0000);
    rd(1, "R8 raw mask", 32'hF0F0_0000);
    look(32'h1FF0_0000); chk("R4 hole clears lower", {31'b0, hit}, 1);
    look(32'h2000_0000); chk("R4 upper compare", {31'b0, hit}, 0);
  endtask

  task automatic t_xlat;
    wr(1, 32'hF0F0_0000); wr(2, 32'hABCD_0000); wr(3, 32'h4);
    look(32'h1F00_0123); chk("R6 translate", out_addr, 32'hAF00_0123);
    wr(1, 32'hFFFF_F000);
    look(32'h1234_5678); chk("R6 full mask", out_addr, 32'hABCD_0678);
    wr(3, 0);
    look(32'h1234_5678); chk("R7 pass", out_addr, 32'h1234_5678);
  endtask

  task automatic t_same_cycle;
    wr(1, 32'hFFFF_0000); wr(0, 32'h5555_0000);
    @(negedge clk);
    in_addr = 32'hAAAA_1234;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'hAAAA_0000;
    #3;
    chk("R2 before edge hit", {31'b0, hit}, 0);
    @(posedge clk); #1;
    cfg_we = 0;
    chk("R2 after edge hit", {31'b0, hit}, 1);
    wr(2, 32'h0BAD_0000);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3; cfg_wdata = 32'h4;
    #3;
    chk("R2 before edge out", out_addr, 32'hAAAA_1234);
    @(posedge clk); #1;
    cfg_we = 0;
    chk("R2 after edge out", out_addr, 32'h0BAD_1234);
    wr(3, 0);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20 t_reset();
    rst_n = 1;
    t_readback();
    t_disabled();
    t_hit();
    t_fix();
    t_xlat();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule